// File: doc/BRIEF.md
# Binary-to-Decimal Character Converter

This block turns the signed mantissa of a 48-bit numeric word into a short run of decimal characters. After a one-cycle `start` pulse it captures the word and a requested field length. It converts the 39-bit magnitude to packed BCD, one binary bit per clock, using the add-three-then-double method. It then streams the low-order digits of the result out as 6-bit characters, most significant first.

Each character carries its digit in the low nibble. When the value is negative, the sign is marked in the zone bits of the final character. While the field is produced, the block checks whether any non-zero digit fell outside the requested width and reports this on a status flag. A consumer collects the characters while `charValid` is high. It treats `charLast` as the end of the field and reads `truncOk` in the cycle that `done` is high.

Top module: `bin_dec_char_conv`

## Requirements
- R1: After reset, `charValid`, `charLast` and `done` are low, `charOut` is zero and `truncOk` is 1.
- R2: The magnitude is taken from word bits 38:0 and the sign from bit 46. All other word bits have no effect on the output.
- R3: The converted value is the decimal form of the magnitude modulo 10^9, held as nine digits numbered 8 (most significant) down to 0.
- R4: When the field length is not zero, the first character is valid exactly 39 cycles after the clock edge that captured `start`.
- R5: For a field length n, exactly n characters appear on consecutive cycles, digit n-1 first and digit 0 last. `charLast` is high only with digit 0. `done` is high for one cycle, in the cycle after the last character.
- R6: Every character has the digit value in bits 3:0 and zeros in the zone bits 5:4, except as stated in R7.
- R7: When sign bit 46 is 1 and the magnitude is not zero, the digit-0 character also has bit 5 set (octal 040). A zero magnitude is always emitted as positive.
- R8: `truncOk` is set to 1 when a non-empty conversion starts. It is cleared when any digit at a position at or above n is non-zero, and it is valid when `done` is high.
- R9: A field length of 0 produces no characters. `done` is high in the cycle after the start edge, and `truncOk` keeps its previous value.
- R10: A field length above 9 is treated as 9.
- R11: A `start` pulse that arrives while a conversion or emission is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a conversion when idle |
| wordIn | input | 48 | Source word (sign bit 46, magnitude bits 38:0) |
| digitCount | input | 4 | Requested number of low-order digits, clamped to 9 |
| charOut | output | 6 | Current character, zone in bits 5:4, digit in bits 3:0 |
| charValid | output | 1 | `charOut` holds a character this cycle |
| charLast | output | 1 | Current character is digit 0 |
| done | output | 1 | One-cycle completion strobe |
| truncOk | output | 1 | 1 when no non-zero digit was cut off |

## Verification
The properties assume that reset is not asserted in the middle of a field. They also assume that `start` is a short pulse, so the control sequence always runs from idle through conversion and emission to the completion cycle. The bench resets only at the beginning of the run and raises `start` for a single cycle. The one exception is a deliberate extra pulse in the middle of a conversion, which is there to show that the pulse is ignored. The word and field length are held steady until the next start, although the design captures them on the start edge anyway.

// File: rtl/bdc_pkg.sv
package bdc_pkg;
  parameter int DIGITS   = 9;
  parameter int MANT_W   = 39;
  parameter int WORD_W   = 48;
  parameter int SIGN_POS = 46;
  parameter int CHAR_W   = 6;
  parameter int LEN_W    = 4;
  localparam int IDX_W   = $clog2(DIGITS);
  localparam int STEP_W  = $clog2(MANT_W);
  localparam int BCD_W   = 4 * DIGITS;

  typedef enum logic [1:0] {ST_IDLE, ST_CONV, ST_EMIT, ST_FIN} convState_t;

  typedef struct packed {
    logic             load;
    logic             step;
    logic             emit;
    logic             evalTrunc;
    logic [IDX_W-1:0] digitSel;
  } strobes_t;
endpackage

// File: rtl/bdc_control.sv
module bdc_control
  import bdc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [LEN_W-1:0] countIn,
  output strobes_t         strb,
  output logic [LEN_W-1:0] fieldLen,
  output logic             lastDigit,
  output logic             finished
);
  convState_t        state;
  logic [STEP_W-1:0] stepCnt;
  logic [IDX_W-1:0]  idx;
  logic [LEN_W-1:0]  clampLen;

  always_comb begin
    clampLen = (countIn > LEN_W'(DIGITS)) ? LEN_W'(DIGITS) : countIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      stepCnt  <= '0;
      idx      <= '0;
      fieldLen <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          fieldLen <= clampLen;
          stepCnt  <= '0;
          state    <= (clampLen == '0) ? ST_FIN : ST_CONV;
        end
        ST_CONV: begin
          stepCnt <= stepCnt + 1'b1;
          if (stepCnt == STEP_W'(MANT_W - 1)) begin
            state <= ST_EMIT;
            idx   <= IDX_W'(fieldLen - 1'b1);
          end
        end
        ST_EMIT: begin
          if (idx == '0) state <= ST_FIN;
          else           idx   <= idx - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.load      = (state == ST_IDLE) && start && (clampLen != '0);
    strb.step      = (state == ST_CONV);
    strb.emit      = (state == ST_EMIT);
    strb.evalTrunc = (state == ST_EMIT) && (idx == '0);
    strb.digitSel  = idx;
    lastDigit      = (state == ST_EMIT) && (idx == '0);
    finished       = (state == ST_FIN);
  end
endmodule

// File: rtl/bdc_datapath.sv
module bdc_datapath
  import bdc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic [MANT_W-1:0] magIn,
  input  logic              signIn,
  input  logic [LEN_W-1:0]  fieldLen,
  output logic [CHAR_W-1:0] charOut,
  output logic              truncOk
);
  logic [MANT_W-1:0] magSh;
  logic [BCD_W-1:0]  bcd;
  logic [BCD_W-1:0]  adj;
  logic              negFlag;
  logic              dropNz;
  logic [3:0]        selDigit;

  for (genvar g = 0; g < DIGITS; g++) begin : g_adj
    assign adj[4*g +: 4] = (bcd[4*g +: 4] >= 4'd5) ? bcd[4*g +: 4] + 4'd3
                                                   : bcd[4*g +: 4];
  end

  always_comb begin
    dropNz   = 1'b0;
    selDigit = '0;
    for (int d = 0; d < DIGITS; d++) begin
      if ((LEN_W'(d) >= fieldLen) && (bcd[4*d +: 4] != 4'd0)) dropNz = 1'b1;
      if (strb.digitSel == IDX_W'(d)) selDigit = bcd[4*d +: 4];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      magSh   <= '0;
      bcd     <= '0;
      negFlag <= 1'b0;
      truncOk <= 1'b1;
    end else if (strb.load) begin
      magSh   <= magIn;
      bcd     <= '0;
      negFlag <= signIn && (magIn != '0);
      truncOk <= 1'b1;
    end else if (strb.step) begin
      magSh <= magSh << 1;
      bcd   <= {adj[BCD_W-2:0], magSh[MANT_W-1]};
    end else if (strb.evalTrunc) begin
      truncOk <= truncOk & ~dropNz;
    end
  end

  always_comb begin
    charOut = '0;
    if (strb.emit) begin
      charOut[3:0]        = selDigit;
      charOut[CHAR_W-1]   = negFlag && (strb.digitSel == '0);
    end
  end
endmodule

// File: rtl/bin_dec_char_conv.sv
module bin_dec_char_conv
  import bdc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [WORD_W-1:0] wordIn,
  input  logic [LEN_W-1:0]  digitCount,
  output logic [CHAR_W-1:0] charOut,
  output logic              charValid,
  output logic              charLast,
  output logic              done,
  output logic              truncOk
);
  strobes_t         strb;
  logic [LEN_W-1:0] fieldLen;

  bdc_control u_ctl (
    .clk(clk), .rstN(rstN), .start(start), .countIn(digitCount),
    .strb(strb), .fieldLen(fieldLen), .lastDigit(charLast), .finished(done)
  );

  bdc_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .magIn(wordIn[MANT_W-1:0]), .signIn(wordIn[SIGN_POS]),
    .fieldLen(fieldLen), .charOut(charOut), .truncOk(truncOk)
  );

  assign charValid = strb.emit;
endmodule

// File: rtl/bdc_checker.sv
module bdc_checker (
  input logic       clk,
  input logic       rstN,
  input logic [5:0] charOut,
  input logic       charValid,
  input logic       charLast,
  input logic       done
);
  // R5
  last_has_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    charLast |-> charValid);
  // R5
  run_contig_chk: assert property (@(posedge clk) disable iff (!rstN)
    (charValid && !charLast) |=> charValid);
  // R5
  last_then_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    charLast |=> done);
  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R6
  digit_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    charValid |-> (charOut[3:0] <= 4'd9));
  // R6
  zone_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (charValid && !charLast) |-> (charOut[5:4] == 2'b00));
  // R7
  zone_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    charValid |-> !charOut[4]);
endmodule

bind bin_dec_char_conv bdc_checker u_chk (.*);

// File: tb/bin_dec_char_conv_bench.sv
module bin_dec_char_conv_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [47:0] wordIn = '0;
  logic [3:0]  digitCount = '0;
  logic [5:0]  charOut;
  logic        charValid, charLast, done, truncOk;
  int          nChecks = 0;
  int          nFails = 0;
  bit          modelTrunc = 1'b1;

  always #4 clk = ~clk;

  bin_dec_char_conv u_bin_dec_char_conv (.*);

  // {word, field length}
  localparam int NV = 8;
  localparam logic [51:0] VEC [NV] = '{
    {48'h0000_0000_3039, 4'd5},   // 12345 full field
    {48'h0000_0000_3039, 4'd3},   // R8 cut-off digits
    {48'h4000_0000_0007, 4'd2},   // R7 negative
    {48'h4000_0000_0000, 4'd4},   // R7 zero treated positive
    {48'h007F_FFFF_FFFF, 4'd12},  // R10 clamp, R3 modulo
    {48'hBF80_3B9A_C9FF, 4'd9},   // R2 other bits ignored
    {48'h4000_3B9A_CA00, 4'd9},   // R3 value wraps to zero
    {48'h4000_0000_0005, 4'd1}    // single negative digit
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic runOne(input logic [47:0] w, input logic [3:0] cnt, input bit midStart);
    longint mag, v, t;
    int dg[9];
    int n, got, firstCyc, doneCyc;
    bit neg, expTrunc;
    mag = longint'(w[38:0]);
    v = mag % 64'd1000000000;
    t = v;
    for (int d = 0; d < 9; d++) begin dg[d] = int'(t % 10); t = t / 10; end
    n = (cnt > 9) ? 9 : int'(cnt);
    neg = w[46] && (mag != 0);
    expTrunc = 1'b1;
    for (int d = n; d < 9; d++) if (dg[d] != 0) expTrunc = 1'b0;
    if (n == 0) expTrunc = modelTrunc;
    @(negedge clk);
    wordIn = w; digitCount = cnt; start = 1'b1;
    got = 0; firstCyc = -1; doneCyc = -1;
    for (int cyc = 0; cyc < 200 && doneCyc < 0; cyc++) begin
      @(negedge clk);
      if (charValid) begin
        int d;
        logic [5:0] e;
        if (firstCyc < 0) firstCyc = cyc;
        d = n - 1 - got;
        e = {(neg && d == 0), 1'b0, 4'(dg[(d < 0) ? 0 : d])};
        chk(d >= 0 && charOut == e, "R3 R6 R7", "char", charOut, e);
        chk(charLast == (d == 0), "R5", "last flag", charLast, d == 0);
        got++;
      end
      if (done) doneCyc = cyc;
      if (cyc == 0) start = 1'b0;
      if (midStart && cyc == 10) begin start = 1'b1; wordIn = ~w; digitCount = 4'd9; end
      if (midStart && cyc == 11) start = 1'b0;
    end
    chk(got == n, "R5", "char count", got, n);
    chk(doneCyc == ((n == 0) ? 0 : 39 + n), "R5 R9", "done cycle", doneCyc, (n == 0) ? 0 : 39 + n);
    if (n > 0) chk(firstCyc == 39, "R4", "first char cycle", firstCyc, 39);
    chk(truncOk == expTrunc, "R8 R9", "truncation flag", truncOk, expTrunc);
    modelTrunc = expTrunc;
    start = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!charValid && !charLast && !done, "R1", "idle strobes", {charValid, charLast, done}, 0);
    chk(charOut == 6'd0, "R1", "char idle", charOut, 0);
    chk(truncOk == 1'b1, "R1", "trunc reset", truncOk, 1);
    @(negedge clk); rstN = 1'b1;
    for (int i = 0; i < NV; i++) runOne(VEC[i][51:4], VEC[i][3:0], 1'b0);
    // R9: field length 0 after a cut-off run keeps the flag at 0
    runOne(48'h0000_0000_3039, 4'd3, 1'b0);
    runOne(48'h0000_0000_1234, 4'd0, 1'b0);
    // R9: field length 0 after a clean run keeps the flag at 1
    runOne(48'h0000_0000_0042, 4'd2, 1'b0);
    runOne(48'h0000_0999_0000, 4'd0, 1'b0);
    // R11: a second start during conversion is ignored
    runOne(48'h0000_0001_E240, 4'd6, 1'b1);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule